// File: doc/BRIEF.md
# Dual-Slope Integrating ADC Sequencer

This block is the digital control half of a dual-slope integrating analog-to-digital converter. It runs from the system clock and drives two control lines towards the analog front end. One line holds the integrator in reset during an auto-zero interval. The other selects what the integrator sees: the unknown voltage or a reference of opposite polarity. The block reads back a single comparator flag that goes high when the integrator output has returned to zero volts.

A conversion has three timed phases. First the integrator is held at zero for a fixed settling interval. Then it integrates the unknown input for exactly 1000 clock cycles. Then it integrates the reference while a four-digit decimal counter runs. The cycle at which the comparator trips ends the second interval. The count reached is the reading, equal to (Vx / Vref) × 1000. Because this ratio is measured by time alone, the integrator's resistor and capacitor values drop out. The reading is held in packed decimal form, so it can drive a four-digit display with the decimal point fixed after the leading digit. For example, 2.75 V against a 1 V reference reads 2.750.

While the run input is high, conversions follow each other back to back. When run is low at the end of a conversion, the block parks with the integrator held at zero. The comparator is asynchronous to the clock and passes through a two-flop synchronizer before the sequencer acts on it.

Top module: `dual_slope_seq`

## Requirements
- R1: After reset `int_zero_o`=1, `sel_ref_o`=0, `done_o`=0, `overrange_o`=0 and `result_bcd_o`=0, and this state holds, with no conversion started, while `run_i` is low.
- R2: When a conversion is started, `int_zero_o` stays high for exactly AZ_CYCLES (default 8) cycles before the run-up begins. This applies to the first sampled cycle with `run_i` high in idle, and to the cycles after a `done_o` pulse while `run_i` stays high.
- R3: The run-up selects the unknown input (`int_zero_o`=0, `sel_ref_o`=0) for exactly RUNUP_COUNT (default 1000) cycles, after which `sel_ref_o` goes high.
- R4: Let k be the number of rising clock edges with `sel_ref_o` high at which the raw `cmp_zero_i` was low, counted before its first high sample. For k ≤ 9999 the reading is k, and `done_o` rises on the fourth cycle after that first high sample.
- R5: `result_bcd_o` holds four packed decimal digits, each 0 to 9. Bits [15:12] are the units digit shown before the fixed decimal point, and bits [11:0] are the three fractional digits, so a count of 1000 reads 16'h1000 (1.000).
- R6: A comparator that is already high on the first run-down edge gives a reading of 0 with no overrange.
- R7: If k ≥ 10000, the conversion ends after 9999 counts, with `overrange_o`=1 and `result_bcd_o`=16'h9999. With k = 9999 the reading is 9999 and `overrange_o`=0.
- R8: `done_o` is high for exactly one cycle per conversion. `result_bcd_o` and `overrange_o` change only in that cycle, so a later in-range result clears `overrange_o`.
- R9: When `run_i` is low on the cycle a result is latched, the block returns to idle: `int_zero_o` stays 1, `sel_ref_o` stays 0, `done_o` stays 0 and the result is held.
- R10: Comparator activity during auto-zero or run-up has no effect on the reading. The comparator only counts once its two-flop synchronizer has seen run-down samples.
- R11: `sel_ref_o` and `int_zero_o` are never high together, and `done_o` only follows a cycle with `sel_ref_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Level: keep converting while high |
| cmp_zero_i | input | 1 | Asynchronous comparator flag, high when the integrator is back at zero |
| int_zero_o | output | 1 | Holds the integrator in reset (auto-zero, idle, latch) |
| sel_ref_o | output | 1 | Integrator input select: 0 unknown voltage, 1 reference |
| done_o | output | 1 | One-cycle strobe when a new result is latched |
| overrange_o | output | 1 | Latched with the result: the comparator did not trip within 9999 counts |
| result_bcd_o | output | 16 | Latched reading, four packed decimal digits |

## Verification
The hardest situation to reach is the edge of the counting range. A reading of exactly 9999 must end as a normal conversion, while one more count must end as an overrange, and both depend on the comparator edge arriving in one exact cycle behind a two-flop synchronizer. The stimulus counts falling clock edges from the moment the run-up starts and raises the comparator on a chosen edge. This places the trip at any exact run-down count, including zero, 9999 and 10000. Random conversions add comparator pulses during the run-up to show that they are ignored.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ZERO  = 3'd1,
        ST_UP    = 3'd2,
        ST_DOWN  = 3'd3,
        ST_LATCH = 3'd4
    } dsq_state_e;

    localparam logic [3:0] BCD_MAX = 4'd9;

    // Next value of one decimal digit when it is stepped.
    function automatic logic [3:0] bcd_digit_step(input logic [3:0] dig);
        return (dig == BCD_MAX) ? 4'd0 : dig + 4'd1;
    endfunction

    // States in which the integrator is clamped to zero.
    function automatic logic is_clamped(input dsq_state_e st);
        return (st == ST_IDLE) || (st == ST_ZERO) || (st == ST_LATCH);
    endfunction

endpackage

// File: rtl/dsq_sync.sv
module dsq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = (sh_q << 1) | STAGES'(d_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/dsq_bcd_counter.sv
module dsq_bcd_counter #(
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  inc_i,
    output logic [4*DIGITS-1:0]   value_o,
    output logic                  full_o
);
    import dsq_pkg::*;

    logic [DIGITS-1:0] carry;
    logic [DIGITS-1:0] nine;

    assign carry[0] = inc_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] dig_d, dig_q;

        always_comb begin
            dig_d = dig_q;
            if (clr_i)         dig_d = 4'd0;
            else if (carry[g]) dig_d = bcd_digit_step(dig_q);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dig_q <= 4'd0;
            else        dig_q <= dig_d;
        end

        assign nine[g]            = (dig_q == BCD_MAX);
        assign value_o[4*g +: 4]  = dig_q;

        if (g < DIGITS-1) begin : g_carry
            assign carry[g+1] = carry[g] & nine[g];
        end

        // R5
        digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dig_q <= BCD_MAX);
    end

    assign full_o = &nine;
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq #(
    parameter int RUNUP_COUNT = 1000,
    parameter int AZ_CYCLES   = 8,
    parameter int DIGITS      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                cmp_zero_i,
    output logic                int_zero_o,
    output logic                sel_ref_o,
    output logic                done_o,
    output logic                overrange_o,
    output logic [4*DIGITS-1:0] result_bcd_o
);
    import dsq_pkg::*;

    localparam int RW   = 4 * DIGITS;
    localparam int TMAX = (RUNUP_COUNT > AZ_CYCLES) ? RUNUP_COUNT : AZ_CYCLES;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] UP_LAST = TW'(RUNUP_COUNT - 1);
    localparam logic [TW-1:0] AZ_LAST = TW'(AZ_CYCLES - 1);
    localparam logic [RW-1:0] ALL_NINES = {DIGITS{4'h9}};

    typedef struct packed {
        dsq_state_e      state;
        logic [TW-1:0]   timer;
        logic [RW-1:0]   result;
        logic            over;
        logic            done;
    } seq_regs_t;

    seq_regs_t       r_d, r_q;
    logic            cmp_s;
    logic            in_down;
    logic            armed;
    logic            cnt_clr, cnt_inc, cnt_full;
    logic [RW-1:0]   cnt_val;

    assign in_down = (r_q.state == ST_DOWN);

    // Comparator crosses into the clock domain here.
    dsq_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_zero_i),
        .q_o   (cmp_s)
    );

    // Matching delay on the run-down flag: the synchronized comparator is
    // trusted only once it carries samples taken during the run-down.
    dsq_sync #(.STAGES(SYNC_STAGES)) u_arm_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (in_down),
        .q_o   (armed)
    );

    dsq_bcd_counter #(.DIGITS(DIGITS)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .inc_i   (cnt_inc),
        .value_o (cnt_val),
        .full_o  (cnt_full)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                cnt_clr = 1'b1;
                if (run_i) begin
                    r_d.state = ST_ZERO;
                    r_d.timer = '0;
                end
            end
            ST_ZERO: begin
                cnt_clr = 1'b1;
                if (r_q.timer == AZ_LAST) begin
                    r_d.state = ST_UP;
                    r_d.timer = '0;
                end else begin
                    r_d.timer = r_q.timer + TW'(1);
                end
            end
            ST_UP: begin
                if (r_q.timer == UP_LAST) begin
                    r_d.state = ST_DOWN;
                    r_d.timer = '0;
                end else begin
                    r_d.timer = r_q.timer + TW'(1);
                end
            end
            ST_DOWN: begin
                if (armed) begin
                    if (cmp_s) begin
                        r_d.state  = ST_LATCH;
                        r_d.result = cnt_val;
                        r_d.over   = 1'b0;
                        r_d.done   = 1'b1;
                    end else if (cnt_full) begin
                        r_d.state  = ST_LATCH;
                        r_d.result = ALL_NINES;
                        r_d.over   = 1'b1;
                        r_d.done   = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_LATCH: begin
                cnt_clr   = 1'b1;
                r_d.timer = '0;
                r_d.state = run_i ? ST_ZERO : ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, timer: '0, result: '0, over: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign int_zero_o   = is_clamped(r_q.state);
    assign sel_ref_o    = in_down;
    assign done_o       = r_q.done;
    assign overrange_o  = r_q.over;
    assign result_bcd_o = r_q.result;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_bcd_o) && $stable(overrange_o)));

    // R7
    over_nines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrange_o |-> (result_bcd_o == ALL_NINES));

    // R11
    done_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(sel_ref_o));

    // R3
    ref_after_runup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_ref_o) |-> $past(!int_zero_o));
endmodule

// File: tb/tb_dual_slope_seq.sv
`timescale 1ns/1ps
module tb_dual_slope_seq;
    localparam int RUNUP = 1000;
    localparam int AZ    = 8;
    localparam int MAXR  = 9999;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        cmp = 1'b0;
    logic        int_zero, sel_ref, done, over;
    logic [15:0] result;

    int checks = 0;
    int errors = 0;
    int res_bad = 0;
    int excl_bad = 0;
    logic [15:0] last_res = '0;
    logic        last_ov  = 1'b0;

    always #2.5 clk = ~clk;

    dual_slope_seq #(.RUNUP_COUNT(RUNUP), .AZ_CYCLES(AZ)) dut (
        .clk(clk), .rst_n(rst_n), .run_i(run), .cmp_zero_i(cmp),
        .int_zero_o(int_zero), .sel_ref_o(sel_ref), .done_o(done),
        .overrange_o(over), .result_bcd_o(result)
    );

    function automatic logic [15:0] to_bcd(input int v);
        logic [15:0] r;
        int t;
        t = v;
        for (int d = 0; d < 4; d++) begin
            r[4*d +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    // Ideal dual-slope count: input over reference, times the run-up length.
    function automatic int ideal_count(input int vx_mv, input int vref_mv);
        return (vx_mv * RUNUP) / vref_mv;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitors for R8 (result only moves with done) and R11 (exclusive controls).
    always @(negedge clk) begin
        if (!rst_n) begin
            last_res = result;
            last_ov  = over;
        end else begin
            if (!done && (result != last_res || over != last_ov)) res_bad++;
            if (int_zero && sel_ref) excl_bad++;
            last_res = result;
            last_ov  = over;
        end
    end

    // Counts clamped cycles starting at the next falling edge.
    task automatic count_zero(output int c);
        c = 0;
        @(negedge clk);
        while (int_zero && c < 200) begin
            c++;
            @(negedge clk);
        end
    endtask

    // Entered on the first falling edge of the run-up.
    task automatic run_conv(input int k, input bit glitch, input int gpos,
                            input bit drop_run, input string req);
        int kk, exp_n, n, az;
        kk    = (k > MAXR) ? MAXR : k;
        exp_n = RUNUP + 4 + kk;
        for (n = 1; n <= exp_n + 5; n++) begin
            if (done) break;
            if (n == RUNUP)
                chk(!sel_ref && !int_zero, "R3", "input still selected", sel_ref, 0);
            if (n == RUNUP + 1)
                chk(sel_ref, "R3", "reference selected", sel_ref, 1);
            if (glitch && n == gpos)     cmp = 1'b1;
            if (glitch && n == gpos + 3) cmp = 1'b0;
            if (n == RUNUP + 1 + k) begin
                cmp = 1'b1;
                if (drop_run) run = 1'b0;
            end
            @(negedge clk);
        end
        chk(n == exp_n, "R4", "done cycle", n, exp_n);
        chk(result == to_bcd(kk), req, "reading", int'(result), int'(to_bcd(kk)));
        chk(over == (k > MAXR), "R7", "overrange flag", over, int'(k > MAXR));
        cmp = 1'b0;
        if (!drop_run) begin
            count_zero(az);
            chk(az == AZ, "R2", "auto-zero cycles after done", az, AZ);
        end else begin
            @(negedge clk);
            chk(!done, "R8", "done width", done, 0);
            for (int i = 0; i < 300; i++) begin
                if (!int_zero || sel_ref || done || result != to_bcd(kk)) begin
                    chk(1'b0, "R9", "idle after run drop", int'(result), int'(to_bcd(kk)));
                    break;
                end
                @(negedge clk);
            end
            chk(int_zero && !sel_ref, "R9", "parked clamped", int_zero, 1);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int az, vx, vref, k;
        bit g;
        void'($urandom(32'd4177));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(int_zero && !sel_ref, "R1", "clamped after reset", int_zero, 1);
        chk(!done && !over, "R1", "no done/overrange", done, 0);
        chk(result == 16'h0, "R1", "result cleared", int'(result), 0);
        repeat (50) @(negedge clk);
        chk(int_zero && !sel_ref && !done, "R1", "idle while run low", sel_ref, 0);

        run = 1'b1;
        count_zero(az);
        chk(az == AZ, "R2", "auto-zero from idle", az, AZ);

        // R5: 1 V against 1 V reads 1.000
        run_conv(ideal_count(1000, 1000), 1'b0, 0, 1'b0, "R5");
        run_conv(ideal_count(2750, 1000), 1'b0, 0, 1'b0, "R4");
        run_conv(0, 1'b0, 0, 1'b0, "R6");
        run_conv(1, 1'b1, 500, 1'b0, "R10");
        run_conv(9999, 1'b0, 0, 1'b0, "R7");
        run_conv(10000, 1'b0, 0, 1'b0, "R7");
        run_conv(1234, 1'b1, 995, 1'b0, "R8");

        for (int i = 0; i < 12; i++) begin
            vx = int'($urandom_range(0, 2999));
            case ($urandom_range(0, 2))
                0:       vref = 1000;
                1:       vref = 1500;
                default: vref = 2000;
            endcase
            k = ideal_count(vx, vref);
            g = 1'($urandom_range(0, 1));
            run_conv(k, g, int'($urandom_range(2, 990)), 1'b0, g ? "R10" : "R4");
        end

        run_conv(321, 1'b0, 0, 1'b1, "R4");

        chk(res_bad == 0, "R8", "result moved without done", res_bad, 0);
        chk(excl_bad == 0, "R11", "clamp and reference together", excl_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule